// File: doc/BRIEF.md
# Transmit Completion Flag Register

This block holds one sticky status bit per message buffer of a message-based transmitter. When the transmit engine finishes sending a buffer, it pulses that buffer's line on `txDone` and the matching flag latches to one. Software clears a flag by writing a zero into its position, and writing a one there changes nothing. A flag is also cleared when software writes a transmit request for the same buffer. The request write arrives here as a one-cycle pulse on `txReq`. If a completion pulse and a clear of either kind hit the same bit in the same cycle, the completion wins.

A second register of the same width holds one interrupt enable per buffer. `irq` is high while at least one flag is set and its enable bit is also set. Both registers sit on a small register bus with a word address, byte-lane enables, a write strobe, a read strobe and a qualifier. The qualifier marks a read that belongs to a read-modify-write sequence. Such a read of the flag register returns all ones, so that writing the value back clears no flag by accident.

Top module: `txc_flag_reg`

## Requirements
- R1: After reset, all flags, all enable bits, `irq` and `busRdata` are zero.
- R2: A one on `txDone[i]` in a cycle leaves flag i at one from the next clock edge on.
- R3: A write to word address 0 (the flag register) clears flag i when its lane enable `busBe[i/8]` is one and `busWdata[i]` is zero. A one in the data, or a disabled lane, leaves the flag unchanged.
- R4: A one on `txReq[i]` clears flag i at the next clock edge.
- R5: When `txDone[i]` and a clear of flag i (from a written zero or from `txReq[i]`) arrive in the same cycle, flag i ends up at one.
- R6: Read data appears on `busRdata` one cycle after the read strobe and holds until the next read. A read of address 0 with `busRmw` high returns all ones. A read of address 0 with `busRmw` low returns the flags. A read of address 1 returns the enables whatever the value of `busRmw`.
- R7: Word address 1 is the interrupt-enable register. A write there updates only the bytes whose `busBe` bit is one, and takes effect at the next edge.
- R8: `irq` is the OR, over all buffers, of flag AND enable. It stays high until every enabled flag is cleared or its enable is removed.
- R9: Writes to addresses 2 and 3 change neither register, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| txDone | input | NUM_BUF | One-cycle completion pulse per buffer |
| txReq | input | NUM_BUF | One-cycle pulse per buffer when its transmit request bit is written with one |
| busAddr | input | ADDR_W | Word address: 0 flags, 1 enables |
| busWe | input | 1 | Write strobe |
| busBe | input | NUM_BUF/8 | Byte-lane enables, bit 0 is bits 7..0 |
| busWdata | input | NUM_BUF | Write data |
| busRe | input | 1 | Read strobe |
| busRmw | input | 1 | Marks the read as part of a read-modify-write |
| busRdata | output | NUM_BUF | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus never writes and reads in the same cycle. They also assume that `busRmw` is only meaningful when `busRe` is high, and that clears occur only in cycles carrying a write or a request pulse. The bench drives each access in its own cycle and returns every strobe to zero at the next falling edge. It combines completion pulses with clears only where it means to test priority. A randomized phase keeps the same rule of one bus access per cycle. That phase also mixes completion and request pulses freely on arbitrary bits.

// File: rtl/txc_pkg.sv
package txc_pkg;
  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic wrFlag;   // write to flag word
    logic wrEn;     // write to enable word
    logic rdFlag;   // plain read of flag word
    logic rdEn;     // read of enable word
    logic rdOnes;   // read-modify-write read of flag word
    logic rdAny;    // any read, loads read data register
  } txcStrobes_t;
endpackage

// File: rtl/txc_reg_ctrl.sv
module txc_reg_ctrl
  import txc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busRmw,
  output txcStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(1);

  logic flagSel;
  logic enSel;

  always_comb begin
    flagSel     = (busAddr == FLAG_ADDR);
    enSel       = (busAddr == EN_ADDR);
    strb.wrFlag = busWe & flagSel;
    strb.wrEn   = busWe & enSel;
    strb.rdOnes = busRe & busRmw & flagSel;
    strb.rdFlag = busRe & ~busRmw & flagSel;
    strb.rdEn   = busRe & enSel;
    strb.rdAny  = busRe;
  end
endmodule

// File: rtl/txc_reg_datapath.sv
module txc_reg_datapath
  import txc_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int LANE_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  txcStrobes_t                 strb,
  input  logic [NUM_BUF-1:0]          txDone,
  input  logic [NUM_BUF-1:0]          txReq,
  input  logic [NUM_BUF/LANE_W-1:0]   busBe,
  input  logic [NUM_BUF-1:0]          busWdata,
  output logic [NUM_BUF-1:0]          flagQ,
  output logic [NUM_BUF-1:0]          enQ,
  output logic [NUM_BUF-1:0]          busRdata,
  output logic                        irq
);
  localparam int NUM_LANES = NUM_BUF / LANE_W;

  logic [NUM_BUF-1:0] laneMask;
  logic [NUM_BUF-1:0] swClr;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneMask[l*LANE_W +: LANE_W] = {LANE_W{busBe[l]}};

    always_ff @(posedge clk) begin
      if (rst)
        enQ[l*LANE_W +: LANE_W] <= '0;
      else if (strb.wrEn && busBe[l])
        enQ[l*LANE_W +: LANE_W] <= busWdata[l*LANE_W +: LANE_W];
    end
  end

  // Written zero in an enabled lane clears; written one is ignored
  assign swClr = {NUM_BUF{strb.wrFlag}} & laneMask & ~busWdata;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flagQ[i] <= 1'b0;
      else if (txDone[i])
        flagQ[i] <= 1'b1;            // completion beats any clear
      else if (txReq[i] || swClr[i])
        flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      busRdata <= '0;
    else if (strb.rdAny) begin
      if (strb.rdOnes)
        busRdata <= '1;
      else if (strb.rdFlag)
        busRdata <= flagQ;
      else if (strb.rdEn)
        busRdata <= enQ;
      else
        busRdata <= '0;
    end
  end

  assign irq = |(flagQ & enQ);
endmodule

// File: rtl/txc_flag_reg.sv
module txc_flag_reg
  import txc_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BUF-1:0]        txDone,
  input  logic [NUM_BUF-1:0]        txReq,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      busWe,
  input  logic [NUM_BUF/LANE_W-1:0] busBe,
  input  logic [NUM_BUF-1:0]        busWdata,
  input  logic                      busRe,
  input  logic                      busRmw,
  output logic [NUM_BUF-1:0]        busRdata,
  output logic                      irq
);
  txcStrobes_t        strb;
  logic [NUM_BUF-1:0] flagVec;
  logic [NUM_BUF-1:0] enVec;

  txc_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .busRmw  (busRmw),
    .strb    (strb)
  );

  txc_reg_datapath #(.NUM_BUF(NUM_BUF), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .txDone   (txDone),
    .txReq    (txReq),
    .busBe    (busBe),
    .busWdata (busWdata),
    .flagQ    (flagVec),
    .enQ      (enVec),
    .busRdata (busRdata),
    .irq      (irq)
  );
endmodule

// File: rtl/txc_flag_reg_chk.sv
module txc_flag_reg_chk #(
  parameter int NUM_BUF = 16,
  parameter int ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_BUF-1:0] txDone,
  input logic [NUM_BUF-1:0] txReq,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic               busRe,
  input logic               busRmw,
  input logic [NUM_BUF-1:0] busRdata,
  input logic               irq,
  input logic [NUM_BUF-1:0] flagVec
);
  p_done_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|txDone) |=> ((flagVec & $past(txDone)) == $past(txDone)));

  p_req_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (|(txReq & ~txDone)) |=> ((flagVec & $past(txReq & ~txDone)) == '0));

  p_no_stray_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!busWe && txReq == '0) |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  p_rmw_ones_r6: assert property (@(posedge clk) disable iff (rst)
    (busRe && busRmw && busAddr == '0) |=> (busRdata == '1));

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busRe) |=> $stable(busRdata));

  p_irq_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !busWe && txReq == '0) |=> irq);
endmodule

bind txc_flag_reg txc_flag_reg_chk #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .txDone   (txDone),
  .txReq    (txReq),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busRe    (busRe),
  .busRmw   (busRmw),
  .busRdata (busRdata),
  .irq      (irq),
  .flagVec  (flagVec)
);

// File: tb/txc_flag_reg_test.sv
module txc_flag_reg_test;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NB-1:0] txDone, txReq, busWdata, busRdata;
  logic [1:0]    busAddr, busBe;
  logic          busWe, busRe, busRmw, irq;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  logic [NB-1:0] mFlags, mEn;       // bench model
  logic [NB-1:0] expQ[$];
  string         tagQ[$];

  always #5 clk = ~clk;

  txc_flag_reg uut (
    .clk(clk), .rst(rst), .txDone(txDone), .txReq(txReq),
    .busAddr(busAddr), .busWe(busWe), .busBe(busBe), .busWdata(busWdata),
    .busRe(busRe), .busRmw(busRmw), .busRdata(busRdata), .irq(irq)
  );

  function automatic logic [NB-1:0] laneMask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // One cycle of stimulus; model updated with completion priority
  task automatic cycle(input logic [NB-1:0] done, input logic [NB-1:0] req,
                       input logic we, input logic [1:0] addr,
                       input logic [1:0] be, input logic [NB-1:0] wd);
    logic [NB-1:0] clr;
    @(negedge clk);
    txDone = done; txReq = req; busWe = we; busAddr = addr;
    busBe = be; busWdata = wd;
    clr = req;
    if (we && addr == 2'd0) clr |= laneMask(be) & ~wd;
    if (we && addr == 2'd1) mEn = (mEn & ~laneMask(be)) | (wd & laneMask(be));
    mFlags = (mFlags & ~clr) | done;
    @(negedge clk);
    txDone = '0; txReq = '0; busWe = 1'b0;
  endtask

  // Read driver: pushes expected value into the scoreboard
  task automatic rd(input logic [1:0] addr, input logic rmw, input string tag);
    logic [NB-1:0] e;
    @(negedge clk);
    busAddr = addr; busRe = 1'b1; busRmw = rmw;
    if (addr == 2'd0) e = rmw ? '1 : mFlags;
    else if (addr == 2'd1) e = mEn;
    else e = '0;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0; busRmw = 1'b0;
  endtask

  task automatic chkIrq(input string tag);
    logic e;
    e = |(mFlags & mEn);
    vectors++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, e);
    end
  endtask

  // Monitor: compares read data the cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (busRe) begin
        @(negedge clk);
        begin
          logic [NB-1:0] e;
          string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          vectors++;
          if (busRdata !== e) begin
            fails++;
            $display("FAIL %s rdata: got %h expected %h", t, busRdata, e);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; txDone = '0; txReq = '0; busAddr = '0; busWe = 1'b0;
    busBe = '0; busWdata = '0; busRe = 1'b0; busRmw = 1'b0;
    mFlags = '0; mEn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    vectors++;
    if (busRdata !== '0) begin
      fails++; $display("FAIL R1 rdata: got %h expected 0000", busRdata);
    end
    chkIrq("R1");
    rd(2'd0, 1'b0, "R1 flags");
    rd(2'd1, 1'b0, "R1 enables");
    // R2 completion sets
    cycle(16'h8001, '0, 1'b0, 2'd0, 2'b00, '0);
    rd(2'd0, 1'b0, "R2");
    // R3 lane-limited zero write, and ones ignored
    cycle('0, '0, 1'b1, 2'd0, 2'b01, 16'h00FE);
    rd(2'd0, 1'b0, "R3 lane");
    cycle('0, '0, 1'b1, 2'd0, 2'b11, 16'hFFFF);
    rd(2'd0, 1'b0, "R3 ones");
    // R7 enable byte lanes, R8 interrupt
    cycle('0, '0, 1'b1, 2'd1, 2'b11, 16'h8000);
    rd(2'd1, 1'b0, "R7 full");
    chkIrq("R8 set");
    cycle('0, '0, 1'b1, 2'd1, 2'b01, 16'h00FF);
    rd(2'd1, 1'b0, "R7 lane");
    // R4 request clears
    cycle('0, 16'h8000, 1'b0, 2'd0, 2'b00, '0);
    rd(2'd0, 1'b0, "R4");
    chkIrq("R8 clear");
    // R5 completion beats software and request clears
    cycle(16'h0008, '0, 1'b1, 2'd0, 2'b11, 16'h0000);
    cycle(16'h0010, 16'h0010, 1'b0, 2'd0, 2'b00, '0);
    rd(2'd0, 1'b0, "R5");
    chkIrq("R8 R5");
    // R6 read-modify-write reads
    rd(2'd0, 1'b1, "R6 rmw flags");
    rd(2'd0, 1'b0, "R6 plain flags");
    rd(2'd1, 1'b1, "R6 rmw enables");
    // R9 unmapped addresses
    cycle('0, '0, 1'b1, 2'd2, 2'b11, 16'h0000);
    cycle('0, '0, 1'b1, 2'd3, 2'b11, 16'hFFFF);
    rd(2'd2, 1'b0, "R9 read");
    rd(2'd0, 1'b0, "R9 flags");
    rd(2'd1, 1'b0, "R9 enables");
    // R8 enabled flags gone, enables still set
    cycle('0, '0, 1'b1, 2'd0, 2'b11, 16'h0000);
    chkIrq("R8 idle");
    // Randomized mix of all sources
    for (int k = 0; k < 200; k++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      cycle(16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom),
            1'($urandom), a, 2'($urandom), 16'($urandom));
      chkIrq("R8 random");
      rd(2'($urandom_range(0, 3)), 1'($urandom), "R6 random");
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule